// File: doc/BRIEF.md
# Dual-Ended Shared Compacting Flit Buffer

This block is the input storage of a router that serves two physical input channels, each multiplexing several virtual channels, from one array of flit slots. Group A keeps its queues packed from the bottom address upward. Group B keeps its queues packed from the top address downward. Within a group every virtual channel owns one contiguous region, and its regions are laid out in ascending channel order along that group's direction of growth. A region never shrinks below a small reserved quota, so an idle channel always has room for its first flits. Beyond its quota a channel borrows from the single free gap between the two groups. When a flit leaves the head of a region, the group closes the hole by moving the data behind it one slot toward the group's end. The reserved slots move with the data.

Each group has its own write port and its own read port, and both groups work in the same cycle. A write port presents a flit and a virtual-channel number, and the flit is taken at the clock edge if that channel's accept bit is high. A read port names a virtual channel. Its head flit is shown combinationally and is removed at the edge when the read enable is high. Per-channel accept and non-empty bits let the neighbouring switch logic schedule traffic without any knowledge of addresses.

Top module: `dual_end_compact_buf`

## Requirements
- R1: While reset is low and in the first cycle after it, every accept bit of both groups is 1 and every non-empty bit is 0.
- R2: Flits written to one virtual channel are read back from it in write order with unchanged data. The read data port shows the head flit of the channel selected by the read channel number whenever that channel's non-empty bit is 1.
- R3: A channel that holds fewer than RESERVE flits always has its accept bit at 1, even when the shared gap is empty.
- R4: A channel that holds RESERVE or more flits accepts only if the shared gap has room. The gap is DEPTH minus the regions of both groups, where each region counts max(count, RESERVE). With a default of group A first, group A may take the last free slot. If exactly one slot is free and group A presents a flit for a channel at or above its quota, group B's at-quota channels show accept 0 in that cycle.
- R5: A write presented while the chosen channel's accept bit is 0 is discarded and leaves no flit behind.
- R6: A read aimed at an empty channel changes nothing: no count, no data and no accept bit.
- R7: With all other channels empty, one channel can hold at most DEPTH - RESERVE*(2*NUM_VC-1) flits, which is 10 for the defaults. The two groups' regions together never exceed DEPTH slots.
- R8: Reads and writes on both groups in the same cycle all take effect, including a read and a write on the same channel. Accept decisions use the counts held before the edge.
- R9: A channel's non-empty bit is 1 from the cycle after an accepted write to it until its last flit is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrValidA | input | 1 | Group A flit present |
| wrVcA | input | VC_W | Group A target virtual channel (binary) |
| wrDataA | input | FLIT_W | Group A flit |
| rdyA | output | NUM_VC | Group A per-channel accept, bit v for channel v |
| rdEnA | input | 1 | Group A remove head of selected channel |
| rdVcA | input | VC_W | Group A read channel (binary) |
| rdDataA | output | FLIT_W | Group A head flit of rdVcA |
| nonEmptyA | output | NUM_VC | Group A per-channel holds data |
| wrValidB | input | 1 | Group B flit present |
| wrVcB | input | VC_W | Group B target virtual channel (binary) |
| wrDataB | input | FLIT_W | Group B flit |
| rdyB | output | NUM_VC | Group B per-channel accept |
| rdEnB | input | 1 | Group B remove head of selected channel |
| rdVcB | input | VC_W | Group B read channel (binary) |
| rdDataB | output | FLIT_W | Group B head flit of rdVcB |
| nonEmptyB | output | NUM_VC | Group B per-channel holds data |

## Verification
The properties assume that reset is held low before the first edge and that channel numbers are always below NUM_VC. They also assume that DEPTH is at least RESERVE*2*NUM_VC, so that the quotas fit in the array from the start. The stimulus only draws channel numbers in range and keeps the default geometry. Writes and reads are issued freely, including against full channels, empty channels and a full array, because discarding those requests is itself required behaviour. Directed sequences drive the array to exactly one and to zero free slots, so that the group-priority rule and the quota rule are both exercised at their boundaries.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  // position/count width; DEPTH must stay below 2**PosW
  localparam int PosW = 8;
  typedef logic [PosW-1:0] pos_t;

  // per-group strobes from control to datapath, in the group's own view
  // (view position 0 is the group's end of the array)
  typedef struct packed {
    logic rdDo;     // remove one flit at rdPos
    pos_t rdPos;    // head slot of the selected channel
    pos_t rdEnd;    // first slot not touched by the compaction
    logic wrDo;     // store a flit
    logic wrGrow;   // store needs a fresh slot from the gap
    pos_t wrPos;    // slot that receives the flit (after the read)
    pos_t growEnd;  // group extent after the read, top of the upward shift
  } grpStrobe_t;
endpackage

// File: rtl/dsb_group_ctrl.sv
module dsb_group_ctrl
  import dsb_pkg::*;
#(
  parameter int DEPTH   = 24,
  parameter int NUM_VC  = 4,
  parameter int RESERVE = 2,
  localparam int VC_W   = $clog2(NUM_VC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [VC_W-1:0]   wrVc,
  input  logic              rdEn,
  input  logic [VC_W-1:0]   rdVc,
  input  logic              growOk,
  output logic              needGrow,
  output logic [NUM_VC-1:0] rdy,
  output logic [NUM_VC-1:0] nonEmpty,
  output pos_t              span,
  output grpStrobe_t        strobe
);
  localparam pos_t ResP = pos_t'(RESERVE);

  pos_t cnt  [NUM_VC];
  pos_t cntM [NUM_VC];
  pos_t cntN [NUM_VC];
  pos_t st   [NUM_VC+1];
  pos_t stM  [NUM_VC+1];
  logic rdOk;
  logic wrOk;

  function automatic pos_t occOf(pos_t c);
    return (c < ResP) ? ResP : c;
  endfunction

  // region starts before this cycle's operations
  always_comb begin
    st[0] = '0;
    for (int v = 0; v < NUM_VC; v++) st[v+1] = st[v] + occOf(cnt[v]);
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_flags
    assign rdy[v]      = (cnt[v] < ResP) || growOk;
    assign nonEmpty[v] = (cnt[v] != '0);
  end

  assign needGrow = wrValid && (cnt[wrVc] >= ResP);
  assign rdOk     = rdEn && nonEmpty[rdVc];
  assign wrOk     = wrValid && rdy[wrVc];
  assign span     = st[NUM_VC];

  // counts after the read, then after the write
  always_comb begin
    for (int v = 0; v < NUM_VC; v++) begin
      cntM[v] = (rdOk && rdVc == VC_W'(v)) ? cnt[v] - pos_t'(1) : cnt[v];
      cntN[v] = (wrOk && wrVc == VC_W'(v)) ? cntM[v] + pos_t'(1) : cntM[v];
    end
  end

  // region starts after the read
  always_comb begin
    stM[0] = '0;
    for (int v = 0; v < NUM_VC; v++) stM[v+1] = stM[v] + occOf(cntM[v]);
  end

  always_comb begin
    strobe.rdDo    = rdOk;
    strobe.rdPos   = st[rdVc];
    strobe.rdEnd   = (cnt[rdVc] > ResP) ? st[NUM_VC] : st[rdVc] + ResP;
    strobe.wrDo    = wrOk;
    strobe.wrGrow  = (cntM[wrVc] >= ResP);
    strobe.wrPos   = stM[wrVc] + cntM[wrVc];
    strobe.growEnd = stM[NUM_VC];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int v = 0; v < NUM_VC; v++) cnt[v] <= '0;
    end else begin
      for (int v = 0; v < NUM_VC; v++) cnt[v] <= cntN[v];
    end
  end
endmodule

// File: rtl/dsb_space_arb.sv
module dsb_space_arb
  import dsb_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter bit A_FIRST = 1'b1
) (
  input  pos_t spanA,
  input  pos_t spanB,
  input  logic needGrowA,
  input  logic needGrowB,
  output logic growOkA,
  output logic growOkB
);
  pos_t freeSlots;
  assign freeSlots = pos_t'(DEPTH) - spanA - spanB;

  // the favoured group may always take a free slot; the other one
  // may take the last slot only if the favoured group does not want it
  if (A_FIRST) begin : g_a_first
    assign growOkA = (freeSlots != '0);
    assign growOkB = (freeSlots >= pos_t'(2)) ||
                     ((freeSlots == pos_t'(1)) && !needGrowA);
  end else begin : g_b_first
    assign growOkB = (freeSlots != '0);
    assign growOkA = (freeSlots >= pos_t'(2)) ||
                     ((freeSlots == pos_t'(1)) && !needGrowB);
  end
endmodule

// File: rtl/dsb_datapath.sv
module dsb_datapath
  import dsb_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int FLIT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  grpStrobe_t        sA,
  input  grpStrobe_t        sB,
  input  logic [FLIT_W-1:0] wrDataA,
  input  logic [FLIT_W-1:0] wrDataB,
  output logic [FLIT_W-1:0] rdDataA,
  output logic [FLIT_W-1:0] rdDataB
);
  typedef logic [DEPTH-1:0][FLIT_W-1:0] memArr_t;

  memArr_t mem;
  memArr_t nxtA;
  memArr_t viewB;
  memArr_t nxt;

  // one group's read compaction followed by its write insertion
  function automatic memArr_t applyGrp(memArr_t a, grpStrobe_t s,
                                       logic [FLIT_W-1:0] d);
    for (int p = 0; p < DEPTH-1; p++)
      if (s.rdDo && pos_t'(p) >= s.rdPos && pos_t'(p+1) < s.rdEnd)
        a[p] = a[p+1];
    for (int p = DEPTH-1; p > 0; p--)
      if (s.wrDo && s.wrGrow && pos_t'(p) > s.wrPos && pos_t'(p) <= s.growEnd)
        a[p] = a[p-1];
    for (int p = 0; p < DEPTH; p++)
      if (s.wrDo && pos_t'(p) == s.wrPos)
        a[p] = d;
    return a;
  endfunction

  always_comb begin
    nxtA = applyGrp(mem, sA, wrDataA);
    for (int p = 0; p < DEPTH; p++) viewB[p] = nxtA[DEPTH-1-p];
    viewB = applyGrp(viewB, sB, wrDataB);
    for (int p = 0; p < DEPTH; p++) nxt[p] = viewB[DEPTH-1-p];
  end

  always_comb begin
    rdDataA = '0;
    rdDataB = '0;
    for (int p = 0; p < DEPTH; p++) begin
      if (pos_t'(p) == sA.rdPos) rdDataA = mem[p];
      if (pos_t'(p) == sB.rdPos) rdDataB = mem[DEPTH-1-p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) mem <= '0;
    else       mem <= nxt;
  end
endmodule

// File: rtl/dual_end_compact_buf.sv
module dual_end_compact_buf
  import dsb_pkg::*;
#(
  parameter int DEPTH   = 24,
  parameter int NUM_VC  = 4,
  parameter int RESERVE = 2,
  parameter int FLIT_W  = 16,
  parameter bit A_FIRST = 1'b1,
  localparam int VC_W   = $clog2(NUM_VC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValidA,
  input  logic [VC_W-1:0]   wrVcA,
  input  logic [FLIT_W-1:0] wrDataA,
  output logic [NUM_VC-1:0] rdyA,
  input  logic              rdEnA,
  input  logic [VC_W-1:0]   rdVcA,
  output logic [FLIT_W-1:0] rdDataA,
  output logic [NUM_VC-1:0] nonEmptyA,
  input  logic              wrValidB,
  input  logic [VC_W-1:0]   wrVcB,
  input  logic [FLIT_W-1:0] wrDataB,
  output logic [NUM_VC-1:0] rdyB,
  input  logic              rdEnB,
  input  logic [VC_W-1:0]   rdVcB,
  output logic [FLIT_W-1:0] rdDataB,
  output logic [NUM_VC-1:0] nonEmptyB
);
  grpStrobe_t sA;
  grpStrobe_t sB;
  pos_t       spanA;
  pos_t       spanB;
  logic       needGrowA;
  logic       needGrowB;
  logic       growOkA;
  logic       growOkB;

  dsb_group_ctrl #(.DEPTH(DEPTH), .NUM_VC(NUM_VC), .RESERVE(RESERVE)) u_ctrlA (
    .clk(clk), .rstN(rstN), .wrValid(wrValidA), .wrVc(wrVcA),
    .rdEn(rdEnA), .rdVc(rdVcA), .growOk(growOkA), .needGrow(needGrowA),
    .rdy(rdyA), .nonEmpty(nonEmptyA), .span(spanA), .strobe(sA)
  );

  dsb_group_ctrl #(.DEPTH(DEPTH), .NUM_VC(NUM_VC), .RESERVE(RESERVE)) u_ctrlB (
    .clk(clk), .rstN(rstN), .wrValid(wrValidB), .wrVc(wrVcB),
    .rdEn(rdEnB), .rdVc(rdVcB), .growOk(growOkB), .needGrow(needGrowB),
    .rdy(rdyB), .nonEmpty(nonEmptyB), .span(spanB), .strobe(sB)
  );

  dsb_space_arb #(.DEPTH(DEPTH), .A_FIRST(A_FIRST)) u_arb (
    .spanA(spanA), .spanB(spanB), .needGrowA(needGrowA), .needGrowB(needGrowB),
    .growOkA(growOkA), .growOkB(growOkB)
  );

  dsb_datapath #(.DEPTH(DEPTH), .FLIT_W(FLIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .sA(sA), .sB(sB),
    .wrDataA(wrDataA), .wrDataB(wrDataB),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );
endmodule

// File: rtl/dsb_checker.sv
module dsb_checker
  import dsb_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int NUM_VC = 4,
  parameter int VC_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValidA,
  input logic [VC_W-1:0]   wrVcA,
  input logic [NUM_VC-1:0] rdyA,
  input logic              rdEnA,
  input logic [VC_W-1:0]   rdVcA,
  input logic [NUM_VC-1:0] nonEmptyA,
  input logic              wrValidB,
  input logic [VC_W-1:0]   wrVcB,
  input logic [NUM_VC-1:0] rdyB,
  input logic              rdEnB,
  input logic [VC_W-1:0]   rdVcB,
  input logic [NUM_VC-1:0] nonEmptyB,
  input pos_t              spanA,
  input pos_t              spanB
);
  // R7: the two groups never overlap
  a_r7_pool_bound: assert property (@(posedge clk) disable iff (!rstN)
    (int'(spanA) + int'(spanB)) <= DEPTH);

  // R3: an empty channel still has its quota and must accept
  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    a_r3_empty_accepts_a: assert property (@(posedge clk) disable iff (!rstN)
      !nonEmptyA[v] |-> rdyA[v]);
    a_r3_empty_accepts_b: assert property (@(posedge clk) disable iff (!rstN)
      !nonEmptyB[v] |-> rdyB[v]);
  end

  // R9: an accepted write shows up as non-empty on the next cycle
  a_r9_write_visible_a: assert property (@(posedge clk) disable iff (!rstN)
    (wrValidA && rdyA[wrVcA]) |=> nonEmptyA[$past(wrVcA)]);
  a_r9_write_visible_b: assert property (@(posedge clk) disable iff (!rstN)
    (wrValidB && rdyB[wrVcB]) |=> nonEmptyB[$past(wrVcB)]);

  // R6: reading an empty channel alone leaves the group untouched
  a_r6_empty_read_a: assert property (@(posedge clk) disable iff (!rstN)
    (rdEnA && !nonEmptyA[rdVcA] && !wrValidA) |=> $stable(nonEmptyA));
  a_r6_empty_read_b: assert property (@(posedge clk) disable iff (!rstN)
    (rdEnB && !nonEmptyB[rdVcB] && !wrValidB) |=> $stable(nonEmptyB));
endmodule

bind dual_end_compact_buf dsb_checker #(.DEPTH(DEPTH), .NUM_VC(NUM_VC), .VC_W(VC_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .wrValidA(wrValidA), .wrVcA(wrVcA), .rdyA(rdyA), .rdEnA(rdEnA), .rdVcA(rdVcA),
  .nonEmptyA(nonEmptyA),
  .wrValidB(wrValidB), .wrVcB(wrVcB), .rdyB(rdyB), .rdEnB(rdEnB), .rdVcB(rdVcB),
  .nonEmptyB(nonEmptyB),
  .spanA(spanA), .spanB(spanB)
);

// File: tb/dual_end_compact_buf_bench.sv
`timescale 1ns/1ps
module dual_end_compact_buf_bench;
  localparam int DEPTH = 24;
  localparam int NUM_VC = 4;
  localparam int RES = 2;
  localparam int W = 16;
  localparam int VC_W = 2;
  localparam int CAP1 = DEPTH - RES*(2*NUM_VC-1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValidA = 0, rdEnA = 0, wrValidB = 0, rdEnB = 0;
  logic [VC_W-1:0] wrVcA = 0, rdVcA = 0, wrVcB = 0, rdVcB = 0;
  logic [W-1:0] wrDataA = 0, wrDataB = 0;
  logic [NUM_VC-1:0] rdyA, rdyB, nonEmptyA, nonEmptyB;
  logic [W-1:0] rdDataA, rdDataB;

  always #2 clk = ~clk;

  dual_end_compact_buf u_dual_end_compact_buf (
    .clk(clk), .rstN(rstN),
    .wrValidA(wrValidA), .wrVcA(wrVcA), .wrDataA(wrDataA), .rdyA(rdyA),
    .rdEnA(rdEnA), .rdVcA(rdVcA), .rdDataA(rdDataA), .nonEmptyA(nonEmptyA),
    .wrValidB(wrValidB), .wrVcB(wrVcB), .wrDataB(wrDataB), .rdyB(rdyB),
    .rdEnB(rdEnB), .rdVcB(rdVcB), .rdDataB(rdDataB), .nonEmptyB(nonEmptyB)
  );

  int tests = 0;
  int fails = 0;
  logic [W-1:0] mq [2][NUM_VC][DEPTH];
  int mc [2][NUM_VC];
  logic [NUM_VC-1:0] obsNeA, obsNeB, obsRdyA, obsRdyB;
  string dataTag = "R2";

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int occ(int c);
    return (c < RES) ? RES : c;
  endfunction

  function automatic int spanOf(int g);
    int s = 0;
    for (int v = 0; v < NUM_VC; v++) s += occ(mc[g][v]);
    return s;
  endfunction

  // accept rule from R3/R4, group A favoured
  function automatic bit expRdy(int g, int v, bit wvA, int vcA);
    int fr = DEPTH - spanOf(0) - spanOf(1);
    if (mc[g][v] < RES) return 1'b1;
    if (g == 0) return fr >= 1;
    return (fr >= 2) || (fr == 1 && !(wvA && mc[0][vcA] >= RES));
  endfunction

  task automatic popPush(int g, bit rd, int rv, bit wr, int wv, logic [W-1:0] d);
    if (rd && mc[g][rv] > 0) begin
      for (int i = 0; i < DEPTH-1; i++) mq[g][rv][i] = mq[g][rv][i+1];
      mc[g][rv]--;
    end
    if (wr) begin
      mq[g][wv][mc[g][wv]] = d;
      mc[g][wv]++;
    end
  endtask

  task automatic cyc(bit wA, int vA, logic [W-1:0] dA, bit rA, int rvA,
                     bit wB, int vB, logic [W-1:0] dB, bit rB, int rvB);
    bit accA, accB;
    @(negedge clk);
    wrValidA = wA; wrVcA = VC_W'(vA); wrDataA = dA; rdEnA = rA; rdVcA = VC_W'(rvA);
    wrValidB = wB; wrVcB = VC_W'(vB); wrDataB = dB; rdEnB = rB; rdVcB = VC_W'(rvB);
    #1;
    obsNeA = nonEmptyA; obsNeB = nonEmptyB; obsRdyA = rdyA; obsRdyB = rdyB;
    for (int v = 0; v < NUM_VC; v++) begin
      chk(mc[0][v] < RES ? "R3" : "R4", $sformatf("rdyA[%0d]", v), int'(rdyA[v]), int'(expRdy(0, v, wA, vA)));
      chk(mc[1][v] < RES ? "R3" : "R4", $sformatf("rdyB[%0d]", v), int'(rdyB[v]), int'(expRdy(1, v, wA, vA)));
      chk("R9", $sformatf("nonEmptyA[%0d]", v), int'(nonEmptyA[v]), int'(mc[0][v] > 0));
      chk("R9", $sformatf("nonEmptyB[%0d]", v), int'(nonEmptyB[v]), int'(mc[1][v] > 0));
    end
    if (mc[0][rvA] > 0) chk(dataTag, "rdDataA", int'(rdDataA), int'(mq[0][rvA][0]));
    if (mc[1][rvB] > 0) chk(dataTag, "rdDataB", int'(rdDataB), int'(mq[1][rvB][0]));
    accA = wA && expRdy(0, vA, wA, vA);
    accB = wB && expRdy(1, vB, wA, vA);
    @(posedge clk);
    popPush(0, rA, rvA, accA, vA, dA);
    popPush(1, rB, rvB, accB, vB, dB);
    #1;
    wrValidA = 0; rdEnA = 0; wrValidB = 0; rdEnB = 0;
  endtask

  task automatic idle();
    cyc(0, 0, '0, 0, 0, 0, 0, '0, 0, 0);
  endtask

  task automatic drainAll();
    for (int k = 0; k < 3*DEPTH; k++)
      cyc(0, 0, '0, 1, k % NUM_VC, 0, 0, '0, 1, k % NUM_VC);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int drained;
    logic [NUM_VC-1:0] neBefore;
    void'($urandom(32'd20240611));
    for (int g = 0; g < 2; g++) for (int v = 0; v < NUM_VC; v++) mc[g][v] = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "rdyA in reset", int'(rdyA), (1 << NUM_VC) - 1);
    chk("R1", "rdyB in reset", int'(rdyB), (1 << NUM_VC) - 1);
    chk("R1", "nonEmptyA in reset", int'(nonEmptyA), 0);
    chk("R1", "nonEmptyB in reset", int'(nonEmptyB), 0);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1", "nonEmpty after reset", int'({nonEmptyA, nonEmptyB}), 0);

    // R7/R5: one channel fills alone, extra write is dropped
    for (int k = 0; k < CAP1 + 3; k++) cyc(1, 0, W'(16'h100 + k), 0, 0, 0, 0, '0, 0, 0);
    chk("R5", "rdyA[0] when full", int'(obsRdyA[0]), 0);
    drained = 0;
    for (int k = 0; k < CAP1 + 4; k++) begin
      cyc(0, 0, '0, 1, 0, 0, 0, '0, 0, 0);
      if (obsNeA[0]) drained++;
    end
    chk("R7", "flits held by a lone channel", drained, CAP1);
    chk("R5", "refused writes left no flit", drained, CAP1);

    // R3: quota still usable with no free gap
    for (int k = 0; k < CAP1; k++) cyc(1, 0, W'(16'h200 + k), 0, 0, 0, 0, '0, 0, 0);
    cyc(0, 0, '0, 0, 0, 1, 2, 16'hB001, 0, 0);
    chk("R3", "rdyB[2] with empty gap, count 0", int'(obsRdyB[2]), 1);
    cyc(0, 0, '0, 0, 0, 1, 2, 16'hB002, 0, 0);
    chk("R3", "rdyB[2] with empty gap, count 1", int'(obsRdyB[2]), 1);
    cyc(0, 0, '0, 0, 0, 1, 2, 16'hB003, 0, 0);
    chk("R4", "rdyB[2] at quota, no gap", int'(obsRdyB[2]), 0);

    // R4: one free slot, both groups want it -> group A wins
    cyc(0, 0, '0, 1, 0, 0, 0, '0, 0, 0);
    cyc(1, 0, 16'hA0F0, 0, 0, 1, 2, 16'hB004, 0, 0);
    chk("R4", "rdyA[0] takes last slot", int'(obsRdyA[0]), 1);
    chk("R4", "rdyB[2] yields last slot", int'(obsRdyB[2]), 0);
    // R4: one free slot, A writes inside its quota -> B may take it
    cyc(0, 0, '0, 1, 0, 0, 0, '0, 0, 0);
    cyc(1, 1, 16'hA111, 0, 0, 1, 2, 16'hB005, 0, 0);
    chk("R4", "rdyB[2] gets slot A does not need", int'(obsRdyB[2]), 1);

    // R6: reading an empty channel changes nothing
    cyc(0, 0, '0, 0, 0, 0, 0, '0, 0, 0);
    neBefore = obsNeA;
    cyc(0, 0, '0, 1, 3, 0, 0, '0, 0, 0);
    idle();
    chk("R6", "nonEmptyA after empty read", int'(obsNeA), int'(neBefore));

    // R8: all four ports in one cycle, same-channel read and write
    cyc(1, 1, 16'hA222, 1, 1, 1, 2, 16'hB006, 1, 2);
    dataTag = "R8";
    drainAll();

    // R8: random concurrent traffic on both groups
    for (int ph = 0; ph < 8; ph++) begin
      int wp = (ph % 2 == 0) ? 80 : 30;
      int rp = (ph % 2 == 0) ? 35 : 85;
      for (int k = 0; k < 500; k++) begin
        cyc($urandom_range(99) < wp, $urandom_range(NUM_VC-1), W'($urandom),
            $urandom_range(99) < rp, $urandom_range(NUM_VC-1),
            $urandom_range(99) < wp, $urandom_range(NUM_VC-1), W'($urandom),
            $urandom_range(99) < rp, $urandom_range(NUM_VC-1));
      end
    end
    drainAll();
    idle();
    chk("R2", "all channels empty after drain", int'({obsNeA, obsNeB}), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule